// File: doc/BRIEF.md
# Frame Pattern Match Dispatcher

This block sits beside a receive buffer and watches each Ethernet frame byte by byte while the frame is written into that buffer. It keeps the leading bytes of the frame in a window register and, at the moment the configured window is complete, compares the chosen window bytes against a bank of programmed patterns. The first enabled pattern that matches selects a route for the frame: hand it to a local accelerator, copy it to processor memory and raise an interrupt, or let it pass with no action. If no pattern matches, or the frame ends before the window fills, a programmable default route applies.

The byte stream is a valid/ready stream owned by the source and the receive buffer. The block only observes the handshake: a byte counts when `s_valid` and `s_ready` are both high on a clock edge, and the block never stalls the stream. The source may idle (valid low) and the buffer may push back (ready low) at any time. Patterns and the global settings are loaded through a 32-bit write port. The window bytes captured at the last decision can be read back through a combinational read port, so the processor can inspect the header of a frame routed to it.

Top module: `frame_match_dispatch`

## Requirements
- R1: After reset `dec_valid` and `irq` are low and every captured word on `rd_data` reads zero.
- R2: A byte is taken only on an edge where `s_valid` and `s_ready` are both high. A frame starts with a taken byte that has `s_first` high (byte index 0). Taken bytes with `s_first` low that arrive outside a frame are ignored.
- R3: The window length comes from bits [1:0] of the global word (write address 0xF0): code 0 selects 16 bytes, code 1 selects 32 bytes, and codes 2 and 3 select 64 bytes, clamped to `WIN_BYTES`. `dec_valid` pulses for one cycle in the cycle after the byte with index length-1 is taken.
- R4: Pattern p occupies write addresses p*32+w. Words w=0..15 hold the compare bytes, with byte 4w+k in bits [8k+7:8k]. Words 16 and 17 hold the byte-enable mask, with bit j of word 16+m enabling byte 32m+j. Byte b takes part only when its mask bit is set and b is inside the current window. A pattern with no enabled bytes matches any frame.
- R5: When several enabled patterns match, the lowest-numbered one wins. Its number is driven on `dec_pat` and `dec_hit` is high.
- R6: When no enabled pattern matches, the route comes from the default action in bits [3:2] of the global word, `dec_hit` is low and `dec_pat` is 0.
- R7: A frame whose last byte is taken before the window fills receives the default route. `dec_hit` is low and the strobe comes in the cycle after that last byte.
- R8: `dec_valid` pulses exactly once for each frame.
- R9: Action codes are in bits [2:1] of pattern word 20 (bit 0 is the enable): 1 is accelerator, 2 is host, and 0 or 3 is pass. On `dec_route` these appear as 1, 2 and 0. For the host route, `irq` pulses once in the cycle after the frame's last byte is taken, and for no other route.
- R10: `rd_data` returns bytes 4*`rd_addr`..4*`rd_addr`+3 of the window as captured at the latest decision, with the lowest byte in bits [7:0]. It changes only when `dec_valid` is asserted.
- R11: A pattern whose enable bit is clear never matches, even if its bytes agree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Stream byte valid (observed) |
| s_ready | input | 1 | Stream byte ready from the receive buffer (observed) |
| s_data | input | 8 | Stream byte |
| s_first | input | 1 | Byte is the first of a frame |
| s_last | input | 1 | Byte is the last of a frame |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 8 | Configuration word address |
| wr_data | input | 32 | Configuration write data |
| rd_addr | input | RAW | Captured window word select |
| rd_data | output | 32 | Captured window word |
| dec_valid | output | 1 | Route decision strobe |
| dec_route | output | 2 | 0 pass, 1 accelerator, 2 host |
| dec_hit | output | 1 | A pattern matched |
| dec_pat | output | PW | Number of the winning pattern |
| irq | output | 1 | Host interrupt pulse at end of frame |

## Verification
The hardest case to reach from the ports is a decision on the exact byte that completes the window while the stream is stalled and has gaps. Here the strobe has to follow the taken byte rather than the cycle count. The stimulus inserts ready-low cycles, in which a byte is offered but not taken, and valid-low cycles. It then compares the strobe cycle with the recorded edge of the window's final taken byte. A second hard case is the host route when the decision and the frame end fall in the same cycle, either in a short frame or in a frame exactly one window long. Directed frames of exactly those lengths check that `irq` and `dec_valid` come together.

// File: rtl/fmd_pkg.sv
package fmd_pkg;
  localparam int BYTES_PER_WORD = 4;
  localparam int CFG_AW         = 8;
  localparam int PAT_STRIDE     = 32;
  localparam int MASK_OFS       = 16;
  localparam int CTRL_OFS       = 20;
  localparam logic [CFG_AW-1:0] GLOBAL_ADDR = 8'hF0;

  typedef enum logic [1:0] {
    RT_PASS  = 2'd0,
    RT_ACCEL = 2'd1,
    RT_HOST  = 2'd2
  } route_e;

  function automatic route_e act_to_route(input logic [1:0] code);
    case (code)
      2'd1:    return RT_ACCEL;
      2'd2:    return RT_HOST;
      default: return RT_PASS;
    endcase
  endfunction
endpackage

// File: rtl/fmd_regs.sv
module fmd_regs
  import fmd_pkg::*;
#(
  parameter int NPAT      = 4,
  parameter int WIN_BYTES = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [CFG_AW-1:0]         wr_addr,
  input  logic [31:0]               wr_data,
  output logic [WIN_BYTES*8-1:0]    pat_val  [NPAT],
  output logic [WIN_BYTES-1:0]      pat_mask [NPAT],
  output logic [NPAT-1:0]           pat_en,
  output logic [1:0]                pat_act  [NPAT],
  output logic [1:0]                size_code,
  output logic [1:0]                dflt_act
);
  localparam int VWORDS = WIN_BYTES / BYTES_PER_WORD;
  localparam int MWORDS = (WIN_BYTES + 31) / 32;
  localparam int OFSW   = $clog2(PAT_STRIDE);
  localparam int SELW   = CFG_AW - OFSW;

  logic [SELW-1:0] sel;
  logic [OFSW-1:0] ofs;
  assign sel = wr_addr[CFG_AW-1:OFSW];
  assign ofs = wr_addr[OFSW-1:0];

  for (genvar p = 0; p < NPAT; p++) begin : g_pat
    logic [WIN_BYTES*8-1:0] val_r;
    logic [MWORDS*32-1:0]   mask_r;
    logic                   en_r;
    logic [1:0]             act_r;
    logic                   wsel;

    assign wsel = wr_en && (sel == SELW'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_r  <= '0;
        mask_r <= '0;
        en_r   <= 1'b0;
        act_r  <= 2'd0;
      end else if (wsel) begin
        for (int w = 0; w < VWORDS; w++)
          if (ofs == OFSW'(w)) val_r[32*w +: 32] <= wr_data;
        for (int m = 0; m < MWORDS; m++)
          if (ofs == OFSW'(MASK_OFS + m)) mask_r[32*m +: 32] <= wr_data;
        if (ofs == OFSW'(CTRL_OFS)) begin
          en_r  <= wr_data[0];
          act_r <= wr_data[2:1];
        end
      end
    end

    assign pat_val[p]  = val_r;
    assign pat_mask[p] = mask_r[WIN_BYTES-1:0];
    assign pat_en[p]   = en_r;
    assign pat_act[p]  = act_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_code <= 2'd0;
      dflt_act  <= 2'd0;
    end else if (wr_en && wr_addr == GLOBAL_ADDR) begin
      size_code <= wr_data[1:0];
      dflt_act  <= wr_data[3:2];
    end
  end
endmodule

// File: rtl/fmd_window.sv
module fmd_window
  import fmd_pkg::*;
#(
  parameter int WIN_BYTES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   beat,
  input  logic                   first,
  input  logic                   last,
  input  logic [7:0]             data,
  input  logic [1:0]             size_code,
  output logic [WIN_BYTES*8-1:0] win_next,
  output logic [WIN_BYTES-1:0]   in_win,
  output logic                   fill_end,
  output logic                   short_end,
  output logic                   frame_start,
  output logic                   frame_end
);
  localparam int IW = $clog2(WIN_BYTES + 1);

  logic [WIN_BYTES*8-1:0] win_q;
  logic [IW-1:0]          cnt_q, idx, len;
  logic                   in_frame_q, open_q, take, undec;
  int                     len_i;

  always_comb begin
    case (size_code)
      2'd0:    len_i = 4 * BYTES_PER_WORD;
      2'd1:    len_i = 8 * BYTES_PER_WORD;
      default: len_i = 16 * BYTES_PER_WORD;
    endcase
    if (len_i > WIN_BYTES) len_i = WIN_BYTES;
    len = IW'(len_i);
  end

  assign take  = beat && (first || in_frame_q);
  assign undec = first || open_q;
  assign idx   = first ? '0 : cnt_q;

  always_comb begin
    win_next = win_q;
    for (int b = 0; b < WIN_BYTES; b++)
      if (take && idx == IW'(b)) win_next[8*b +: 8] = data;
  end

  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_inwin
    assign in_win[b] = IW'(b) < len;
  end

  assign fill_end    = take && undec && ((idx + IW'(1)) == len);
  assign short_end   = take && undec && last && !fill_end;
  assign frame_start = take && first;
  assign frame_end   = take && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q      <= '0;
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      open_q     <= 1'b0;
    end else if (take) begin
      win_q      <= win_next;
      in_frame_q <= !last;
      open_q     <= undec && !fill_end && !last;
      cnt_q      <= (idx < IW'(WIN_BYTES)) ? idx + IW'(1) : idx;
    end
  end
endmodule

// File: rtl/fmd_matcher.sv
module fmd_matcher #(
  parameter int NPAT      = 4,
  parameter int WIN_BYTES = 64,
  parameter int PW        = 2
) (
  input  logic [WIN_BYTES*8-1:0] win,
  input  logic [WIN_BYTES-1:0]   in_win,
  input  logic [WIN_BYTES*8-1:0] pat_val  [NPAT],
  input  logic [WIN_BYTES-1:0]   pat_mask [NPAT],
  input  logic [NPAT-1:0]        pat_en,
  input  logic [1:0]             pat_act  [NPAT],
  output logic                   any_hit,
  output logic [PW-1:0]          hit_idx,
  output logic [1:0]             hit_act
);
  logic [NPAT-1:0] match;

  for (genvar p = 0; p < NPAT; p++) begin : g_cmp
    logic [WIN_BYTES-1:0] byte_ok;
    for (genvar b = 0; b < WIN_BYTES; b++) begin : g_byte
      assign byte_ok[b] = !(pat_mask[p][b] && in_win[b]) ||
                          (win[8*b +: 8] == pat_val[p][8*b +: 8]);
    end
    assign match[p] = pat_en[p] && (&byte_ok);
  end

  always_comb begin
    any_hit = |match;
    hit_idx = '0;
    hit_act = 2'd0;
    for (int p = NPAT - 1; p >= 0; p--) begin
      if (match[p]) begin
        hit_idx = PW'(p);
        hit_act = pat_act[p];
      end
    end
  end
endmodule

// File: rtl/frame_match_dispatch.sv
module frame_match_dispatch
  import fmd_pkg::*;
#(
  parameter  int NPAT      = 4,
  parameter  int WIN_BYTES = 64,
  localparam int PW        = (NPAT > 1) ? $clog2(NPAT) : 1,
  localparam int RAW       = $clog2(WIN_BYTES / BYTES_PER_WORD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_first,
  input  logic              s_last,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [RAW-1:0]    rd_addr,
  output logic [31:0]       rd_data,
  output logic              dec_valid,
  output logic [1:0]        dec_route,
  output logic              dec_hit,
  output logic [PW-1:0]     dec_pat,
  output logic              irq
);
  logic [WIN_BYTES*8-1:0] pat_val  [NPAT];
  logic [WIN_BYTES-1:0]   pat_mask [NPAT];
  logic [NPAT-1:0]        pat_en;
  logic [1:0]             pat_act  [NPAT];
  logic [1:0]             size_code, dflt_act;

  logic [WIN_BYTES*8-1:0] win_next;
  logic [WIN_BYTES-1:0]   in_win;
  logic                   fill_end, short_end, frame_start, frame_end;

  logic                   m_hit;
  logic [PW-1:0]          m_idx;
  logic [1:0]             m_act;

  fmd_regs #(.NPAT(NPAT), .WIN_BYTES(WIN_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pat_val(pat_val), .pat_mask(pat_mask), .pat_en(pat_en), .pat_act(pat_act),
    .size_code(size_code), .dflt_act(dflt_act)
  );

  fmd_window #(.WIN_BYTES(WIN_BYTES)) u_win (
    .clk(clk), .rst_n(rst_n), .beat(s_valid && s_ready), .first(s_first),
    .last(s_last), .data(s_data), .size_code(size_code), .win_next(win_next),
    .in_win(in_win), .fill_end(fill_end), .short_end(short_end),
    .frame_start(frame_start), .frame_end(frame_end)
  );

  fmd_matcher #(.NPAT(NPAT), .WIN_BYTES(WIN_BYTES), .PW(PW)) u_match (
    .win(win_next), .in_win(in_win), .pat_val(pat_val), .pat_mask(pat_mask),
    .pat_en(pat_en), .pat_act(pat_act), .any_hit(m_hit), .hit_idx(m_idx),
    .hit_act(m_act)
  );

  logic                   decide, won;
  route_e                 new_route, route_q;
  logic                   dec_valid_q, hit_q, irq_q, host_pend_q;
  logic [PW-1:0]          pat_q;
  logic [WIN_BYTES*8-1:0] hdr_q;

  assign decide    = fill_end || short_end;
  assign won       = fill_end && m_hit;
  assign new_route = won ? act_to_route(m_act) : act_to_route(dflt_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_q <= 1'b0;
      irq_q       <= 1'b0;
      host_pend_q <= 1'b0;
      route_q     <= RT_PASS;
      hit_q       <= 1'b0;
      pat_q       <= '0;
      hdr_q       <= '0;
    end else begin
      dec_valid_q <= decide;
      irq_q       <= frame_end && (decide ? (new_route == RT_HOST) : host_pend_q);
      if (decide) begin
        route_q     <= new_route;
        hit_q       <= won;
        pat_q       <= won ? m_idx : '0;
        hdr_q       <= win_next;
        host_pend_q <= (new_route == RT_HOST) && !frame_end;
      end else if (frame_start || frame_end) begin
        host_pend_q <= 1'b0;
      end
    end
  end

  assign dec_valid = dec_valid_q;
  assign dec_route = route_q;
  assign dec_hit   = hit_q;
  assign dec_pat   = pat_q;
  assign irq       = irq_q;
  assign rd_data   = hdr_q[{rd_addr, 5'b0} +: 32];
endmodule

// File: rtl/fmd_checker.sv
module fmd_checker #(
  parameter int RAW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           s_valid,
  input logic           s_ready,
  input logic           s_last,
  input logic [RAW-1:0] rd_addr,
  input logic [31:0]    rd_data,
  input logic           dec_valid,
  input logic [1:0]     dec_route,
  input logic           irq
);
  logic host_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_wait <= 1'b0;
    else if (dec_valid && dec_route == 2'd2 && !irq) host_wait <= 1'b1;
    else if (irq) host_wait <= 1'b0;
  end

  AST_DEC_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(s_valid && s_ready)); // R3

  AST_IRQ_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(s_valid && s_ready && s_last)); // R9

  AST_IRQ_HOST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((dec_valid && dec_route == 2'd2) || host_wait)); // R9

  AST_ROUTE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_route != 2'd3)); // R9

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_valid && rd_addr == $past(rd_addr)) |-> $stable(rd_data)); // R10
endmodule

bind frame_match_dispatch fmd_checker #(.RAW(RAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_last(s_last),
  .rd_addr(rd_addr), .rd_data(rd_data), .dec_valid(dec_valid),
  .dec_route(dec_route), .irq(irq)
);

// File: tb/frame_match_dispatch_tb.sv
module frame_match_dispatch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_ready = 1'b1, s_first = 1'b0, s_last = 1'b0;
  logic [7:0]  s_data = 8'd0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = 8'd0;
  logic [31:0] wr_data = 32'd0;
  logic [3:0]  rd_addr = 4'd0;
  logic [31:0] rd_data;
  logic        dec_valid, dec_hit, irq;
  logic [1:0]  dec_route, dec_pat;

  frame_match_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_first(s_first), .s_last(s_last), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .dec_valid(dec_valid),
    .dec_route(dec_route), .dec_hit(dec_hit), .dec_pat(dec_pat), .irq(irq)
  );

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0, cyc = 0;
  int dec_n = 0, dec_c = 0, dec_r = 0, dec_h = 0, dec_p = 0, irq_n = 0, irq_c = 0;
  int beat_cyc [128];
  logic [7:0]  fb [128];
  logic [7:0]  pv [4][64];
  logic [63:0] pm [4];
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dec_valid) begin
        dec_n++; dec_c = cyc; dec_r = dec_route; dec_h = dec_hit; dec_p = dec_pat;
      end
      if (irq) begin irq_n++; irq_c = cyc; end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_global(input int code, input int dflt);
    wr(8'hF0, 32'((dflt << 2) | code));
  endtask

  task automatic load_pat(input int p, input int en, input int act);
    for (int w = 0; w < 16; w++)
      wr(p * 32 + w, {pv[p][4*w+3], pv[p][4*w+2], pv[p][4*w+1], pv[p][4*w]});
    wr(p * 32 + 16, pm[p][31:0]);
    wr(p * 32 + 17, pm[p][63:32]);
    wr(p * 32 + 20, 32'((act << 1) | en));
  endtask

  task automatic clear_all();
    for (int p = 0; p < 4; p++) begin
      pm[p] = '0;
      for (int b = 0; b < 64; b++) pv[p][b] = 8'd0;
      load_pat(p, 0, 0);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 128; i++) fb[i] = 8'((i * 29 + seed * 7 + 1) & 255);
  endtask

  task automatic send_frame(input int n, input bit stall);
    for (int i = 0; i < n; i++) begin
      if (stall && (i % 3 == 1)) begin
        @(negedge clk);
        s_valid = 1'b1; s_ready = 1'b0; s_data = fb[i];
        s_first = (i == 0); s_last = (i == n - 1);
        @(negedge clk);
        s_valid = 1'b0; s_ready = 1'b1;
      end
      @(negedge clk);
      s_valid = 1'b1; s_ready = 1'b1; s_data = fb[i];
      s_first = (i == 0); s_last = (i == n - 1);
      beat_cyc[i] = cyc;
    end
    @(negedge clk);
    s_valid = 1'b0; s_first = 1'b0; s_last = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_frame(input string tag, input int n, input bit stall, input int win,
                           input int er, input int eh, input int ep);
    int d0, i0, k;
    d0 = dec_n; i0 = irq_n;
    send_frame(n, stall);
    k = (n < win) ? n - 1 : win - 1;
    chk({tag, " R8 one strobe"}, dec_n - d0, 1);
    chk({tag, " R3 strobe cycle"}, dec_c, beat_cyc[k] + 1);
    chk({tag, " route"}, dec_r, er);
    chk({tag, " hit"}, dec_h, eh);
    chk({tag, " pattern"}, dec_p, ep);
    chk({tag, " R9 irq count"}, irq_n - i0, (er == 2) ? 1 : 0);
    if (er == 2) chk({tag, " R9 irq cycle"}, irq_c, beat_cyc[n - 1] + 1);
  endtask

  task automatic t_reset();
    chk("R1 dec_valid", int'(dec_valid), 0);
    chk("R1 irq", int'(irq), 0);
    rd_addr = 4'd0; #1;
    chk("R1 capture word0", int'(rd_data), 0);
    rd_addr = 4'd15; #1;
    chk("R1 capture word15", int'(rd_data), 0);
  endtask

  task automatic t_l2_accel();
    fill(1); clear_all(); set_global(0, 0);
    for (int b = 0; b < 6; b++) begin pm[0][b] = 1'b1; pv[0][b] = fb[b]; end
    load_pat(0, 1, 1);
    run_frame("R4 l2 header accel", 40, 0, 16, 1, 1, 0);
  endtask

  task automatic t_priority();
    fill(2); clear_all(); set_global(0, 0);
    pm[0][0] = 1'b1; pv[0][0] = ~fb[0]; load_pat(0, 1, 1);
    pm[1][12] = 1'b1; pm[1][13] = 1'b1; pv[1][12] = fb[12]; pv[1][13] = fb[13];
    load_pat(1, 1, 2);
    pm[2][14] = 1'b1; pv[2][14] = fb[14]; load_pat(2, 1, 1);
    run_frame("R5 lowest match wins host", 30, 0, 16, 2, 1, 1);
    rd_addr = 4'd3; #1;
    chk("R10 capture word3", int'(rd_data), int'({fb[15], fb[14], fb[13], fb[12]}));
    rd_addr = 4'd0; #1;
    chk("R10 capture word0", int'(rd_data), int'({fb[3], fb[2], fb[1], fb[0]}));
  endtask

  task automatic t_disabled();
    fill(3); clear_all(); set_global(0, 1);
    pm[3][0] = 1'b1; pv[3][0] = fb[0]; load_pat(3, 0, 2);
    run_frame("R11 R6 disabled pattern default", 20, 0, 16, 1, 0, 0);
  endtask

  task automatic t_mask_window();
    fill(4); clear_all(); set_global(0, 0);
    pm[2][2] = 1'b1; pv[2][2] = fb[2];
    pv[2][3] = ~fb[3];
    pm[2][20] = 1'b1; pv[2][20] = ~fb[20];
    load_pat(2, 1, 1);
    run_frame("R4 masked and out-of-window bytes ignored", 24, 0, 16, 1, 1, 2);
  endtask

  task automatic t_payload_64();
    fill(5); clear_all(); set_global(2, 0);
    pm[1][1] = 1'b1; pv[1][1] = fb[1];
    pm[1][50] = 1'b1; pv[1][50] = fb[50];
    load_pat(1, 1, 2);
    run_frame("R3 payload byte 64-byte window", 80, 0, 64, 2, 1, 1);
    fill(6);
    pv[1][1] = fb[1]; pv[1][50] = fb[50];
    load_pat(1, 1, 2);
    set_global(3, 0);
    run_frame("R3 size code 3", 70, 0, 64, 2, 1, 1);
  endtask

  task automatic t_short();
    fill(7); set_global(1, 2);
    run_frame("R7 short frame default host", 10, 0, 32, 2, 0, 0);
  endtask

  task automatic t_stall();
    fill(8); clear_all(); set_global(1, 0);
    pm[0][31] = 1'b1; pv[0][31] = fb[31]; load_pat(0, 1, 1);
    run_frame("R2 stalls and gaps", 40, 1, 32, 1, 1, 0);
  endtask

  task automatic t_act3();
    fill(9); clear_all(); set_global(0, 1);
    pm[0][0] = 1'b1; pv[0][0] = fb[0]; load_pat(0, 1, 3);
    run_frame("R9 action 3 passes", 18, 0, 16, 0, 1, 0);
  endtask

  task automatic t_stray();
    int d0, i0;
    fill(10); clear_all(); set_global(0, 2);
    d0 = dec_n; i0 = irq_n;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_ready = 1'b1; s_data = fb[i]; s_first = 1'b0; s_last = (i == 19);
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 stray bytes no strobe", dec_n - d0, 0);
    chk("R2 stray bytes no irq", irq_n - i0, 0);
    run_frame("R8 exact window frame host", 16, 0, 16, 2, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_l2_accel();
    t_priority();
    t_disabled();
    t_mask_window();
    t_payload_64();
    t_short();
    t_stall();
    t_act3();
    t_stray();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule